// File: doc/BRIEF.md
# Raster Scan Timer with Scaled Cell Grid

This block produces the scan timing for a 640x480 picture refreshed at about 60 Hz, clocked at the 25.175 MHz pixel rate. A horizontal counter walks across each line and a vertical counter advances once per line. From these two counts the block derives active-low horizontal and vertical sync, a one-cycle line-start strobe and a one-cycle frame-start strobe, and the current visible pixel position with a separate valid flag per axis.

For a low-resolution framebuffer of 64 by 32 one-bit cells, each cell covers an 8x8 square of screen pixels. The cell area is 512x256 pixels, centred on the screen. The block reports the cell column and row under the beam, together with a flag that says whether the beam is inside the cell area. A pixel source uses the column and row to look up a framebuffer bit. A checkerboard output built from the cell position lets the timing be checked on a monitor without any framebuffer.

The vertical timing is not the common 525-line mode. It uses 480 visible lines, a front porch of 11, a sync of 2 and a back porch of 31, for 524 lines in total. Every count, porch, scale factor and grid size is a parameter.

Top module: `vga_scan_timer`

## Requirements
- R1: The horizontal count runs 0 to 799 and then returns to 0, so a line lasts 800 clocks (640 visible + 16 front porch + 96 sync + 48 back porch).
- R2: The vertical count advances only in the clock where the horizontal count returns to 0, runs 0 to 523 and then returns to 0 (480 visible + 11 front porch + 2 sync + 31 back porch).
- R3: `hsync_n` is 0 exactly while the horizontal count is from 656 to 751, and 1 otherwise.
- R4: `vsync_n` is 0 exactly while the vertical count is 491 or 492, and 1 otherwise.
- R5: `line_start` is 1 exactly when the horizontal count is 656.
- R6: `frame_start` is 1 exactly when the horizontal count is 656 and the vertical count is 491.
- R7: `px_x_ok` is 1 exactly when the horizontal count is below 640, and `px_x` then equals the count. `px_y_ok` and `px_y` work the same way against 480. A position whose flag is 0 reads as 0.
- R8: `cell_ok` is 1 exactly when the horizontal count is in 64..575 and the vertical count is in 112..367. In that case `cell_x` = (horizontal count − 64) / 8 and `cell_y` = (vertical count − 112) / 8. Otherwise both read as 0.
- R9: `checker_on` equals bit 0 of `cell_x` XOR bit 0 of `cell_y` while `cell_ok` is 1, and is 0 otherwise.
- R10: A clock edge with `rst_n` at 0 sets both counts to 0. The next clock after `rst_n` returns to 1 advances the horizontal count to 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous reset, active low |
| hsync_n | output | 1 | Horizontal sync, active low |
| vsync_n | output | 1 | Vertical sync, active low |
| line_start | output | 1 | High for one clock at the horizontal sync start |
| frame_start | output | 1 | High for one clock at the vertical sync start of the frame |
| px_x | output | CNT_W | Visible column, 0 when not visible |
| px_x_ok | output | 1 | Column is visible |
| px_y | output | CNT_W | Visible row, 0 when not visible |
| px_y_ok | output | 1 | Row is visible |
| cell_x | output | CXW | Cell column in the scaled grid |
| cell_y | output | CYW | Cell row in the scaled grid |
| cell_ok | output | 1 | Beam is inside the cell area |
| checker_on | output | 1 | Checkerboard test pixel |

## Verification
The default instance runs for many consecutive lines with no reset. This tries every horizontal count and the vertical range through the top border into the cell area, and it tells apart off-by-one errors in the porch, sync and border edges. A second instance has small timing parameters and goes through many complete frames. It reaches the vertical sync, the frame strobe and the vertical wrap, which the default mode would take too many cycles to reach. Reset pulses of random length are applied at random points in the scan. They separate a correct restart to count zero from a counter that holds stale state or resumes out of step.

// File: rtl/vga_scan_pkg.sv
// Package: default raster timing and cell-grid constants shared by the
// scan timer and its bench. Assumes a pixel clock near 25.175 MHz.
package vga_scan_pkg;
    localparam int DEF_CNT_W   = 10;
    localparam int DEF_H_VIS   = 640;
    localparam int DEF_H_FRONT = 16;
    localparam int DEF_H_SYNC  = 96;
    localparam int DEF_H_BACK  = 48;
    localparam int DEF_V_VIS   = 480;
    localparam int DEF_V_FRONT = 11;
    localparam int DEF_V_SYNC  = 2;
    localparam int DEF_V_BACK  = 31;
    localparam int DEF_SCALE_SH = 3;
    localparam int DEF_CELLS_X = 64;
    localparam int DEF_CELLS_Y = 32;
endpackage

// File: rtl/scan_axis_counter.sv
// Module: wrapping counter for one scan axis. Advances when adv is high,
// returns to zero after TOTAL-1. Assumes TOTAL fits in W bits.
module scan_axis_counter #(
    parameter int W     = 10,
    parameter int TOTAL = 800
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         adv,
    output logic [W-1:0] count,
    output logic         at_end
);
    localparam logic [W-1:0] LAST = W'(TOTAL - 1);

    // Flags the final count of the axis.
    always_comb at_end = (count == LAST);

    // Counts with wrap; synchronous active-low clear.
    always_ff @(posedge clk) begin
        if (!rst_n)
            count <= '0;
        else if (adv)
            count <= at_end ? '0 : count + W'(1);
    end

    // R1/R2: wrap to zero after the last count
    assert_counter_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && at_end) |=> (count == '0));
    // R1/R2: single step otherwise
    assert_counter_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && !at_end) |=> (count == $past(count) + W'(1)));
    // R2: no movement without an advance
    assert_counter_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !adv |=> $stable(count));
    // R1/R2: never beyond the last count
    assert_counter_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
        count <= LAST);
endmodule

// File: rtl/scan_axis_decode.sv
// Module: decodes one axis count into sync, sync-start strobe, visible
// position and scaled cell index. Assumes VIS >= CELLS << SH.
module scan_axis_decode #(
    parameter int W     = 10,
    parameter int VIS   = 640,
    parameter int FRONT = 16,
    parameter int SYNC  = 96,
    parameter int CELLS = 64,
    parameter int SH    = 3,
    parameter int CW    = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [W-1:0]  count,
    output logic          sync_n,
    output logic          at_sync_begin,
    output logic          vis_ok,
    output logic [W-1:0]  vis_pos,
    output logic          cell_ok,
    output logic [CW-1:0] cell_pos
);
    localparam int SPAN   = CELLS << SH;
    localparam int BORDER = (VIS - SPAN) / 2;
    localparam logic [W-1:0] S_BEG   = W'(VIS + FRONT);
    localparam logic [W-1:0] S_END   = W'(VIS + FRONT + SYNC);
    localparam logic [W-1:0] VIS_L   = W'(VIS);
    localparam logic [W-1:0] CELL_LO = W'(BORDER);
    localparam logic [W-1:0] CELL_HI = W'(BORDER + SPAN);

    // Sync window and its first count.
    always_comb begin
        sync_n        = !((count >= S_BEG) && (count < S_END));
        at_sync_begin = (count == S_BEG);
    end

    // Visible position, zero outside the visible span.
    always_comb begin
        vis_ok  = (count < VIS_L);
        vis_pos = vis_ok ? count : '0;
    end

    // Cell index by dropping SH low bits of the border-relative position.
    always_comb begin
        cell_ok  = (count >= CELL_LO) && (count < CELL_HI);
        cell_pos = cell_ok ? CW'((count - CELL_LO) >> SH) : '0;
    end

    // R3/R4: sync never overlaps the visible span
    assert_sync_blank_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !sync_n |-> !vis_ok);
    // R8: cell area lies inside the visible span
    assert_cell_inside_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cell_ok |-> vis_ok);
endmodule

// File: rtl/vga_scan_timer.sv
// Module: raster scan timer top. Chains a horizontal and a vertical axis
// counter, decodes both axes and forms line/frame strobes, the combined
// cell position and a checkerboard test pixel. Outputs are decoded from
// the registered counts in the same cycle. Synchronous active-low reset.
module vga_scan_timer
    import vga_scan_pkg::*;
#(
    parameter int CNT_W    = DEF_CNT_W,
    parameter int H_VIS    = DEF_H_VIS,
    parameter int H_FRONT  = DEF_H_FRONT,
    parameter int H_SYNC   = DEF_H_SYNC,
    parameter int H_BACK   = DEF_H_BACK,
    parameter int V_VIS    = DEF_V_VIS,
    parameter int V_FRONT  = DEF_V_FRONT,
    parameter int V_SYNC   = DEF_V_SYNC,
    parameter int V_BACK   = DEF_V_BACK,
    parameter int SCALE_SH = DEF_SCALE_SH,
    parameter int CELLS_X  = DEF_CELLS_X,
    parameter int CELLS_Y  = DEF_CELLS_Y,
    parameter int CXW      = $clog2(CELLS_X),
    parameter int CYW      = $clog2(CELLS_Y)
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic             hsync_n,
    output logic             vsync_n,
    output logic             line_start,
    output logic             frame_start,
    output logic [CNT_W-1:0] px_x,
    output logic             px_x_ok,
    output logic [CNT_W-1:0] px_y,
    output logic             px_y_ok,
    output logic [CXW-1:0]   cell_x,
    output logic [CYW-1:0]   cell_y,
    output logic             cell_ok,
    output logic             checker_on
);
    localparam int H_TOTAL = H_VIS + H_FRONT + H_SYNC + H_BACK;
    localparam int V_TOTAL = V_VIS + V_FRONT + V_SYNC + V_BACK;

    logic [CNT_W-1:0] h_cnt, v_cnt;
    logic             h_end, v_end;
    logic             h_sbeg, v_sbeg;
    logic             h_cok, v_cok;
    logic [CXW-1:0]   h_cell;
    logic [CYW-1:0]   v_cell;

    scan_axis_counter #(.W(CNT_W), .TOTAL(H_TOTAL)) u_hcnt (
        .clk(clk), .rst_n(rst_n), .adv(1'b1), .count(h_cnt), .at_end(h_end));

    scan_axis_counter #(.W(CNT_W), .TOTAL(V_TOTAL)) u_vcnt (
        .clk(clk), .rst_n(rst_n), .adv(h_end), .count(v_cnt), .at_end(v_end));

    scan_axis_decode #(.W(CNT_W), .VIS(H_VIS), .FRONT(H_FRONT), .SYNC(H_SYNC),
        .CELLS(CELLS_X), .SH(SCALE_SH), .CW(CXW)) u_hdec (
        .clk(clk), .rst_n(rst_n), .count(h_cnt), .sync_n(hsync_n),
        .at_sync_begin(h_sbeg), .vis_ok(px_x_ok), .vis_pos(px_x),
        .cell_ok(h_cok), .cell_pos(h_cell));

    scan_axis_decode #(.W(CNT_W), .VIS(V_VIS), .FRONT(V_FRONT), .SYNC(V_SYNC),
        .CELLS(CELLS_Y), .SH(SCALE_SH), .CW(CYW)) u_vdec (
        .clk(clk), .rst_n(rst_n), .count(v_cnt), .sync_n(vsync_n),
        .at_sync_begin(v_sbeg), .vis_ok(px_y_ok), .vis_pos(px_y),
        .cell_ok(v_cok), .cell_pos(v_cell));

    // Line and frame strobes at the sync-start counts.
    always_comb begin
        line_start  = h_sbeg;
        frame_start = h_sbeg && v_sbeg;
    end

    // Combined cell position, zero outside the cell area.
    always_comb begin
        cell_ok = h_cok && v_cok;
        cell_x  = cell_ok ? h_cell : '0;
        cell_y  = cell_ok ? v_cell : '0;
    end

    // Checkerboard test pixel from the cell parity.
    always_comb checker_on = cell_ok && (cell_x[0] ^ cell_y[0]);

    // R5: line strobe coincides with the horizontal sync start
    assert_line_in_sync_R5: assert property (@(posedge clk) disable iff (!rst_n)
        line_start |-> !hsync_n);
    // R6: frame strobe is a line strobe inside vertical sync
    assert_frame_in_sync_R6: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |-> (line_start && !vsync_n));
    // R2: vertical count wraps only at the end of a line
    assert_vwrap_at_line_end_R2: assert property (@(posedge clk) disable iff (!rst_n)
        v_end && !h_end |=> v_end);
    // R9: checker pixel only inside the cell area
    assert_checker_gated_R9: assert property (@(posedge clk) disable iff (!rst_n)
        checker_on |-> cell_ok);
    // R10: reset leaves the scan at the top-left position
    assert_reset_clear_R10: assert property (@(posedge clk)
        !rst_n |=> (px_x == '0 && px_y == '0 && px_x_ok && px_y_ok));
endmodule

// File: tb/vga_scan_timer_test.sv
// Bench: drives clock and randomly timed resets; compares every output of a
// default instance and of a small-timing instance against a model computed
// from the cycle count since reset.
module vga_scan_timer_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    longint cyc = 0;
    int vectors = 0;
    int miscompares = 0;
    bit done = 1'b0;

    always #4 clk = ~clk; // 125 MHz

    // Default-mode outputs.
    logic hs_a, vs_a, ls_a, fs_a, xok_a, yok_a, cok_a, chk_a;
    logic [9:0] x_a, y_a;
    logic [5:0] cx_a;
    logic [4:0] cy_a;
    // Small-timing outputs.
    logic hs_b, vs_b, ls_b, fs_b, xok_b, yok_b, cok_b, chk_b;
    logic [9:0] x_b, y_b;
    logic [3:0] cx_b;
    logic [2:0] cy_b;

    vga_scan_timer uut (
        .clk(clk), .rst_n(rst_n), .hsync_n(hs_a), .vsync_n(vs_a),
        .line_start(ls_a), .frame_start(fs_a), .px_x(x_a), .px_x_ok(xok_a),
        .px_y(y_a), .px_y_ok(yok_a), .cell_x(cx_a), .cell_y(cy_a),
        .cell_ok(cok_a), .checker_on(chk_a));

    vga_scan_timer #(
        .H_VIS(40), .H_FRONT(3), .H_SYNC(5), .H_BACK(2),
        .V_VIS(24), .V_FRONT(2), .V_SYNC(3), .V_BACK(1),
        .SCALE_SH(1), .CELLS_X(16), .CELLS_Y(8)
    ) uut_small (
        .clk(clk), .rst_n(rst_n), .hsync_n(hs_b), .vsync_n(vs_b),
        .line_start(ls_b), .frame_start(fs_b), .px_x(x_b), .px_x_ok(xok_b),
        .px_y(y_b), .px_y_ok(yok_b), .cell_x(cx_b), .cell_y(cy_b),
        .cell_ok(cok_b), .checker_on(chk_b));

    typedef struct {
        int hs, vs, ls, fs, x, xok, y, yok, cx, cy, cok, chk;
    } exp_t;

    // Expected outputs t clocks after the last reset edge (R1..R10).
    function automatic exp_t model(longint t, int hv, int hf, int hw, int hb,
                                   int vv, int vf, int vw, int vb,
                                   int sh, int ncx, int ncy);
        exp_t e;
        int ht = hv + hf + hw + hb;
        int vt = vv + vf + vw + vb;
        int h = int'(t % ht);
        int v = int'((t / ht) % vt);
        int bx = (hv - (ncx << sh)) / 2;
        int by = (vv - (ncy << sh)) / 2;
        e.hs  = (h >= hv + hf && h < hv + hf + hw) ? 0 : 1;
        e.vs  = (v >= vv + vf && v < vv + vf + vw) ? 0 : 1;
        e.ls  = (h == hv + hf) ? 1 : 0;
        e.fs  = (e.ls == 1 && v == vv + vf) ? 1 : 0;
        e.xok = (h < hv) ? 1 : 0;
        e.x   = e.xok ? h : 0;
        e.yok = (v < vv) ? 1 : 0;
        e.y   = e.yok ? v : 0;
        e.cok = (h >= bx && h < bx + (ncx << sh) &&
                 v >= by && v < by + (ncy << sh)) ? 1 : 0;
        e.cx  = e.cok ? (h - bx) >> sh : 0;
        e.cy  = e.cok ? (v - by) >> sh : 0;
        e.chk = e.cok ? ((e.cx ^ e.cy) & 1) : 0;
        return e;
    endfunction

    task automatic cmp(string unit, string field, string req, int got, int exp);
        if (got != exp) begin
            miscompares++;
            $display("FAIL %s %s.%s at cycle %0d: got %0d expected %0d",
                     req, unit, field, cyc, got, exp);
        end
    endtask

    // Cycle count since the last reset edge.
    always @(posedge clk) cyc <= rst_n ? cyc + 1 : 0;

    // Compare both instances away from the active edge.
    always @(negedge clk) begin
        if (!done) begin
            exp_t a, b;
            string rq;
            a = model(cyc, 640, 16, 96, 48, 480, 11, 2, 31, 3, 64, 32);
            b = model(cyc, 40, 3, 5, 2, 24, 2, 3, 1, 1, 16, 8);
            rq = (cyc == 0) ? "R10" : "R1";
            vectors += 2;
            cmp("dflt", "hsync_n", "R3", int'(hs_a), a.hs);
            cmp("dflt", "vsync_n", "R4", int'(vs_a), a.vs);
            cmp("dflt", "line_start", "R5", int'(ls_a), a.ls);
            cmp("dflt", "frame_start", "R6", int'(fs_a), a.fs);
            cmp("dflt", "px_x", {rq, "/R7"}, int'(x_a), a.x);
            cmp("dflt", "px_x_ok", "R7", int'(xok_a), a.xok);
            cmp("dflt", "px_y", "R2/R7", int'(y_a), a.y);
            cmp("dflt", "px_y_ok", "R7", int'(yok_a), a.yok);
            cmp("dflt", "cell_x", "R8", int'(cx_a), a.cx);
            cmp("dflt", "cell_y", "R8", int'(cy_a), a.cy);
            cmp("dflt", "cell_ok", "R8", int'(cok_a), a.cok);
            cmp("dflt", "checker_on", "R9", int'(chk_a), a.chk);
            cmp("small", "hsync_n", "R3", int'(hs_b), b.hs);
            cmp("small", "vsync_n", "R4", int'(vs_b), b.vs);
            cmp("small", "line_start", "R5", int'(ls_b), b.ls);
            cmp("small", "frame_start", "R6", int'(fs_b), b.fs);
            cmp("small", "px_x", {rq, "/R7"}, int'(x_b), b.x);
            cmp("small", "px_x_ok", "R7", int'(xok_b), b.xok);
            cmp("small", "px_y", "R2/R7", int'(y_b), b.y);
            cmp("small", "px_y_ok", "R7", int'(yok_b), b.yok);
            cmp("small", "cell_x", "R8", int'(cx_b), b.cx);
            cmp("small", "cell_y", "R8", int'(cy_b), b.cy);
            cmp("small", "cell_ok", "R8", int'(cok_b), b.cok);
            cmp("small", "checker_on", "R9", int'(chk_b), b.chk);
        end
    end

    // Stimulus: long directed run, then random reset pulses and run lengths.
    initial begin
        void'($urandom(32'd2018));
        // R10: reset state held for several clocks
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        // R1/R2/R8: default mode through the top border into the cell area
        repeat (140000) @(negedge clk);
        for (int i = 0; i < 6; i++) begin
            rst_n = 1'b0;
            repeat (1 + $urandom % 4) @(negedge clk);
            rst_n = 1'b1;
            repeat (1000 + $urandom % 2000) @(negedge clk);
        end
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    // Watchdog: a hung run is a failed check.
    initial begin
        repeat (195000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            miscompares++;
            $display("FAIL watchdog expired at cycle %0d: got running expected finished", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end
endmodule